// File: doc/BRIEF.md
# Discrete I/O Port with Input Clamp

This block is the discrete input/output unit that sits beside a 4-bit processor core. It carries out three single-cycle commands issued by the core: a read of input group A, a read of input group B through a mask, and a write that joins the accumulator and the X register into one 8-bit output word. The write also loads a 4-bit clamp register. The clamp drives the bidirectional lines of group B, and because those inputs are open-drain, any clamp bit held low forces the matching input bit to read as zero.

The block also holds a free-running divider that raises a one-clock cycle enable once in every 18 crystal clocks. Command strobes take effect only on a clock edge where that enable is high. A read result is registered and appears on the accumulator port, with a one-cycle valid flag, in the cycle after the accepted strobe.

Top module: `dio_port`

## Requirements
- R1: While reset is asserted and right after it, the clamp reads 4'b1111, the output bus reads 8'h00, the accumulator result reads 4'h0, the valid flag is low and the cycle enable is low.
- R2: The cycle enable is high for exactly one clock in every 18. It first goes high on the 17th rising edge after reset is released, then on every 18th edge after that.
- R3: An accepted write sets the output bus to {X, A}, with A on bits 3:0 and X on bits 7:4, and sets the clamp to X. Both changes show in the cycle after the strobe.
- R4: The output bus and the clamp hold their values until the next accepted write.
- R5: An accepted group A read sets the accumulator result to the low 4 bits of group A and raises the valid flag for one cycle. Both show in the cycle after the strobe.
- R6: An accepted group B read sets the accumulator result to group B ANDed bit by bit with the clamp value held before that edge, and raises the valid flag for one cycle.
- R7: A strobe on an edge where the cycle enable is low has no effect on the accumulator result, the valid flag, the output bus or the clamp.
- R8: On edges without an accepted read, the accumulator result keeps its value and the valid flag is low.
- R9: After reset and before any write, a group B read returns the group B input unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_en | output | 1 | One-clock cycle enable, once per DIV clocks |
| rd_grp_a | input | 1 | Strobe: read input group A |
| rd_grp_b | input | 1 | Strobe: read input group B through the clamp |
| wr_out | input | 1 | Strobe: write output word and load clamp |
| acc_in | input | NIB_W | Accumulator value from the core |
| xreg_in | input | NIB_W | X register value from the core |
| grp_a | input | GA_W | Discrete input group A |
| grp_b | input | NIB_W | Discrete input group B (open-drain) |
| acc_res | output | NIB_W | Accumulator result of the last read |
| acc_vld | output | 1 | High for one cycle after an accepted read |
| dout | output | 2*NIB_W | Discrete output word {X, A} |
| clamp | output | NIB_W | Clamp value driven onto the group B lines |

## Verification
A clamp register holding the wrong value shows on the clamp port one cycle after a write, and shows again in the next group B read as wrongly masked accumulator bits. A divider that drifts or sticks shows on cyc_en within 18 clocks, and it also changes which strobes are accepted, so reads and writes land or vanish out of step with the enable. A result register that fails to hold shows on acc_res on the first edge without a read, and a valid flag that stays high shows one cycle later.

// File: rtl/dio_pkg.sv
// Shared types for the discrete I/O port.
// Assumes: nibble-wide data paths; the read selector is decoded in the top.
package dio_pkg;
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_A    = 2'd1,
        RSEL_B    = 2'd2
    } rsel_e;
endpackage

// File: rtl/dio_cycdiv.sv
// Free-running divider that raises a one-clock enable once every DIV clocks.
// Assumes: DIV >= 2; the enable is decoded from the registered count.
module dio_cycdiv #(
    parameter int DIV = 18
) (
    input  logic clk,
    input  logic rst_n,
    output logic en
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // Enable on the last count of each period.
    always_comb en = (cnt == LAST);

    // Independent gap counter: clocks since the last enable.
    logic [CW:0] gap;
    always_ff @(posedge clk) begin
        if (!rst_n)  gap <= '0;
        else if (en) gap <= '0;
        else         gap <= gap + 1'b1;
    end

    AST_EN_GAP:  assert property (@(posedge clk) disable iff (!rst_n) en |=> !en);  // R2
    AST_GAP_MAX: assert property (@(posedge clk) disable iff (!rst_n) gap < (CW+1)'(DIV));  // R2
endmodule

// File: rtl/dio_rdpath.sv
// Read path: picks group A or masked group B into the accumulator result.
// Assumes: the selector is already qualified by the cycle enable.
module dio_rdpath
    import dio_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int GA_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rsel_e            sel,
    input  logic [GA_W-1:0]  grp_a,
    input  logic [NIB_W-1:0] grp_b,
    input  logic [NIB_W-1:0] mask,
    output logic [NIB_W-1:0] res,
    output logic             vld
);
    logic [NIB_W-1:0] nxt;

    // Pick the new result; open-drain inputs read low where the mask is low.
    always_comb begin
        case (sel)
            RSEL_A:  nxt = grp_a[NIB_W-1:0];
            RSEL_B:  nxt = grp_b & mask;
            default: nxt = res;
        endcase
    end

    // Register the result and the one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
            vld <= 1'b0;
        end else begin
            res <= nxt;
            vld <= (sel != RSEL_NONE);
        end
    end

    AST_VLD_RISE:  assert property (@(posedge clk) disable iff (!rst_n) (sel != RSEL_NONE) |=> vld);  // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sel == RSEL_NONE) |=> ($stable(res) && !vld));  // R8
    AST_B_MASKED:  assert property (@(posedge clk) disable iff (!rst_n) (sel == RSEL_B) |=> ((res & ~$past(mask)) == '0));  // R6
endmodule

// File: rtl/dio_wrpath.sv
// Write path: output word latch and clamp register.
// Assumes: the write strobe is already qualified by the cycle enable.
module dio_wrpath #(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [NIB_W-1:0]   a,
    input  logic [NIB_W-1:0]   x,
    output logic [2*NIB_W-1:0] dout,
    output logic [NIB_W-1:0]   clamp
);
    // Load output word {X, A} and clamp from X on a write; reset opens the clamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            clamp <= '1;
        end else if (wr) begin
            dout  <= {x, a};
            clamp <= x;
        end
    end

    AST_CLAMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wr |=> (clamp == $past(x)));  // R3
    AST_OUT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !wr |=> ($stable(dout) && $stable(clamp)));  // R4
    AST_OUT_LINK:   assert property (@(posedge clk) disable iff (!rst_n) wr |=> (dout[2*NIB_W-1:NIB_W] == clamp));  // R3
endmodule

// File: rtl/dio_port.sv
// Discrete I/O port: divider, command qualification, read and write paths.
// Assumes: command strobes are single-cycle and mutually exclusive.
module dio_port
    import dio_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int GA_W  = 4,
    parameter int DIV   = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               cyc_en,
    input  logic               rd_grp_a,
    input  logic               rd_grp_b,
    input  logic               wr_out,
    input  logic [NIB_W-1:0]   acc_in,
    input  logic [NIB_W-1:0]   xreg_in,
    input  logic [GA_W-1:0]    grp_a,
    input  logic [NIB_W-1:0]   grp_b,
    output logic [NIB_W-1:0]   acc_res,
    output logic               acc_vld,
    output logic [2*NIB_W-1:0] dout,
    output logic [NIB_W-1:0]   clamp
);
    rsel_e sel;
    logic  wr_q;

    dio_cycdiv #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cyc_en)
    );

    // Accept strobes only on enabled edges.
    always_comb begin
        wr_q = wr_out & cyc_en;
        if (cyc_en && rd_grp_a)      sel = RSEL_A;
        else if (cyc_en && rd_grp_b) sel = RSEL_B;
        else                         sel = RSEL_NONE;
    end

    dio_rdpath #(.NIB_W(NIB_W), .GA_W(GA_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .grp_a (grp_a),
        .grp_b (grp_b),
        .mask  (clamp),
        .res   (acc_res),
        .vld   (acc_vld)
    );

    dio_wrpath #(.NIB_W(NIB_W)) u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_q),
        .a     (acc_in),
        .x     (xreg_in),
        .dout  (dout),
        .clamp (clamp)
    );

    AST_IGNORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> (!acc_vld && $stable(acc_res) && $stable(dout) && $stable(clamp)));  // R7
    AST_WR_WORD:    assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out && cyc_en) |=> (dout == {$past(xreg_in), $past(acc_in)}));  // R3
endmodule

// File: tb/sim_dio_port.sv
module sim_dio_port;
    localparam int NIB_W = 4;
    localparam int GA_W  = 4;
    localparam int DIV   = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_en;
    logic rd_grp_a = 1'b0, rd_grp_b = 1'b0, wr_out = 1'b0;
    logic [NIB_W-1:0] acc_in = '0, xreg_in = '0, grp_b = '0;
    logic [GA_W-1:0] grp_a = '0;
    logic [NIB_W-1:0] acc_res, clamp;
    logic acc_vld;
    logic [2*NIB_W-1:0] dout;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dio_port #(.NIB_W(NIB_W), .GA_W(GA_W), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
        .rd_grp_a(rd_grp_a), .rd_grp_b(rd_grp_b), .wr_out(wr_out),
        .acc_in(acc_in), .xreg_in(xreg_in), .grp_a(grp_a), .grp_b(grp_b),
        .acc_res(acc_res), .acc_vld(acc_vld), .dout(dout), .clamp(clamp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_en();
        @(negedge clk);
        while (!cyc_en) @(negedge clk);
    endtask

    // Issue an accepted command (0 = read A, 1 = read B, 2 = write).
    task automatic issue(input int cmd);
        wait_en();
        rd_grp_a = (cmd == 0);
        rd_grp_b = (cmd == 1);
        wr_out   = (cmd == 2);
        @(negedge clk);
        rd_grp_a = 1'b0; rd_grp_b = 1'b0; wr_out = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 clamp", clamp, 4'hF);
        chk("R1 dout", dout, 8'h00);
        chk("R1 acc", acc_res, 4'h0);
        chk("R1 vld", acc_vld, 1'b0);
        chk("R1 en", cyc_en, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_divider();
        int n = 0;
        int m = 0;
        @(negedge clk); n = 1;
        while (!cyc_en && n < 40) begin @(negedge clk); n++; end
        chk("R2 first enable edge", n, 17);
        @(negedge clk); m = 1;
        while (!cyc_en && m < 40) begin @(negedge clk); m++; end
        chk("R2 period", m, DIV);
    endtask

    task automatic t_unmasked();
        grp_b = 4'hA;
        issue(1);
        chk("R9 unmasked B", acc_res, 4'hA);
        chk("R6 vld", acc_vld, 1'b1);
        @(negedge clk);
        chk("R8 vld low", acc_vld, 1'b0);
        chk("R8 acc hold", acc_res, 4'hA);
    endtask

    task automatic t_read_a();
        grp_a = 4'h6;
        issue(0);
        chk("R5 read A", acc_res, 4'h6);
        chk("R5 vld", acc_vld, 1'b1);
        grp_a = 4'h9;
        issue(0);
        chk("R5 read A second", acc_res, 4'h9);
    endtask

    task automatic t_write();
        acc_in = 4'h3; xreg_in = 4'h5;
        issue(2);
        chk("R3 dout", dout, 8'h53);
        chk("R3 clamp", clamp, 4'h5);
        acc_in = 4'hC; xreg_in = 4'hE;
        repeat (5) @(negedge clk);
        chk("R4 dout hold", dout, 8'h53);
        chk("R4 clamp hold", clamp, 4'h5);
    endtask

    task automatic t_masked();
        grp_b = 4'hF;
        issue(1);
        chk("R6 masked B 5", acc_res, 4'h5);
        acc_in = 4'h0; xreg_in = 4'h2;
        issue(2);
        chk("R3 dout 2", dout, 8'h20);
        grp_b = 4'hE;
        issue(1);
        chk("R6 masked B 2", acc_res, 4'h2);
    endtask

    task automatic t_ignored();
        @(negedge clk);
        while (cyc_en) @(negedge clk);
        grp_a = 4'h1; acc_in = 4'h7; xreg_in = 4'h0;
        wr_out = 1'b1;
        @(negedge clk);
        wr_out = 1'b0;
        chk("R7 dout unchanged", dout, 8'h20);
        chk("R7 clamp unchanged", clamp, 4'h2);
        while (cyc_en) @(negedge clk);
        rd_grp_a = 1'b1;
        @(negedge clk);
        rd_grp_a = 1'b0;
        chk("R7 acc unchanged", acc_res, 4'h2);
        chk("R7 vld low", acc_vld, 1'b0);
    endtask

    initial begin
        t_reset();
        t_divider();
        t_unmasked();
        t_read_a();
        t_write();
        t_masked();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule